// File: doc/BRIEF.md
# Bit-Alias Access Bridge

This bridge sits between a processor-side bus port and a word-addressed memory or register bank. Two address windows, one for the memory area and one for the peripheral register area, expose every bit of every covered 32-bit word at its own address. When the processor reads such an alias address, the bridge returns the selected bit as bit 0 of an otherwise zero word. When it writes an alias address, the bridge reads the underlying word, replaces the selected bit and writes the word back. The processor sees a single transfer that is held with a ready signal for one extra cycle. Any address outside the two windows passes straight through as a plain word access.

A second, word-only requester, such as a DMA engine, shares the downstream bus. The bridge raises a bus lock output for the whole internal read-modify-write. While the lock is up the second requester is held off, so nothing can touch the word between the internal read and the write back. The processor port wins whenever both requesters ask in the same idle cycle.

Top module: `bitalias_bridge`

## Requirements
- R1: For window base A mapped onto word base W, the alias address A + k*128 + n*4 (k below REGION_WORDS, n from 0 to 31) selects bit n of the word at W + k*4. The two low address bits are ignored. The memory window and the peripheral window each have their own A and W.
- R2: An alias read completes in the cycle it is presented. It returns bit n of the target word in bit 0, and bits 31..1 are zero.
- R3: An alias write sets bit n of the target word to bit 0 of the write data. Write data bits 31..1 have no effect.
- R4: An alias write leaves the other 31 bits of the target word at the values they held before the write.
- R5: An alias write takes two cycles with ready low in the first. The first cycle reads the target word downstream and the second writes the merged word back to the same address.
- R6: The bus lock output is high in both cycles of an alias write and low during alias reads, plain accesses and idle cycles.
- R7: An access outside both windows, including the word just past a window and the word just below it, reaches the downstream bus with its address, direction and data unchanged, and completes in one cycle.
- R8: A second-requester access presented while an alias write is in progress is not granted until the lock has dropped. It then completes with its own address and data.
- R9: When both requesters ask in the same idle cycle, the processor port is served first and the second requester waits.
- R10: After reset, with no request pending, the lock is low and neither port signals ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data, valid with ready |
| cpu_ready | output | 1 | Processor transfer completes at this clock edge |
| dma_req | input | 1 | Second requester request, held until ready |
| dma_we | input | 1 | Second requester write (1) or read (0) |
| dma_addr | input | ADDR_W | Second requester word address |
| dma_wdata | input | 32 | Second requester write data |
| dma_rdata | output | 32 | Second requester read data |
| dma_ready | output | 1 | Second requester transfer completes at this edge |
| mem_req | output | 1 | Downstream access strobe |
| mem_we | output | 1 | Downstream write enable |
| mem_addr | output | ADDR_W | Downstream word address |
| mem_wdata | output | 32 | Downstream write data |
| mem_rdata | input | 32 | Downstream read data, same cycle |
| mem_lock | output | 1 | Arbitration lock held across the read-modify-write |

## Verification
The two functions that can coincide are the processor's alias read-modify-write and a plain word write from the second requester to the same target word. The bench starts both in the same cycle, and again with the second requester one cycle late so that it lands on the write-back cycle. It then checks the cycle count each side sees: two for the alias write and three or two for the stalled write. It also reads back the final word, which must hold the second requester's data written after the merge and never a mix of the two.

// File: rtl/bitalias_pkg.sv
// Package: shared constants, the sequencer state type and the bit merge
// helper for the bit-alias bridge. Assumes 32-bit data words addressed in
// bytes, so a word occupies four byte addresses.
package bitalias_pkg;

    localparam int BUS_W      = 32;
    localparam int BIT_W      = $clog2(BUS_W);
    localparam int BYTE_SHIFT = 2;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_MERGE = 1'b1
    } seq_state_t;

    // Return word w with bit idx replaced by val.
    function automatic logic [BUS_W-1:0] put_bit(
        input logic [BUS_W-1:0] w,
        input logic [BIT_W-1:0] idx,
        input logic             val
    );
        logic [BUS_W-1:0] r;
        r      = w;
        r[idx] = val;
        return r;
    endfunction

endpackage

// File: rtl/bitalias_decode.sv
// Alias window decoder: checks an address against the memory and peripheral
// alias windows and, on a hit, produces the target word address and the bit
// index. Assumes the alias bases are aligned to 128 bytes (one word's alias
// span), so the bit index can be taken straight from the address.
module bitalias_decode
    import bitalias_pkg::*;
#(
    parameter int                ADDR_W          = 32,
    parameter int                REGION_WORDS    = 262144,
    parameter logic [ADDR_W-1:0] SRAM_ALIAS_BASE = 32'h2200_0000,
    parameter logic [ADDR_W-1:0] SRAM_WORD_BASE  = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] PERI_ALIAS_BASE = 32'h4200_0000,
    parameter logic [ADDR_W-1:0] PERI_WORD_BASE  = 32'h4000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] word_addr,
    output logic [BIT_W-1:0]  bit_idx
);

    localparam int                NUM_WIN     = 2;
    localparam int                ALIAS_SHIFT = BIT_W + BYTE_SHIFT;
    localparam logic [ADDR_W-1:0] ALIAS_SPAN  = ADDR_W'(REGION_WORDS * (2 ** ALIAS_SHIFT));

    logic [NUM_WIN-1:0] win_hit;
    logic [ADDR_W-1:0]  win_word [NUM_WIN];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam logic [ADDR_W-1:0] A_BASE = (g == 0) ? SRAM_ALIAS_BASE : PERI_ALIAS_BASE;
        localparam logic [ADDR_W-1:0] W_BASE = (g == 0) ? SRAM_WORD_BASE  : PERI_WORD_BASE;
        logic [ADDR_W-1:0] offs;
        // Offset into this window and the word it lands on.
        assign offs        = addr - A_BASE;
        assign win_hit[g]  = (addr >= A_BASE) && (offs < ALIAS_SPAN);
        assign win_word[g] = W_BASE + ((offs >> ALIAS_SHIFT) << BYTE_SHIFT);
    end

    // Pick the window that hit; windows are assumed not to overlap.
    always_comb begin
        hit       = |win_hit;
        word_addr = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (win_hit[i]) word_addr = win_word[i];
        end
    end

    assign bit_idx = addr[ALIAS_SHIFT-1:BYTE_SHIFT];

endmodule

// File: rtl/bitalias_rmw_seq.sv
// Processor-side sequencer: serves plain word accesses and alias reads in
// one cycle, and runs alias writes as a locked two-cycle read then merged
// write. Assumes the downstream bank answers reads in the same cycle and
// that the processor holds its request stable until ready.
module bitalias_rmw_seq
    import bitalias_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BUS_W-1:0]  cpu_wdata,
    output logic [BUS_W-1:0]  cpu_rdata,
    output logic              cpu_ready,
    input  logic              alias_hit,
    input  logic [ADDR_W-1:0] alias_word,
    input  logic [BIT_W-1:0]  alias_bit,
    output logic              sq_req,
    output logic              sq_we,
    output logic [ADDR_W-1:0] sq_addr,
    output logic [BUS_W-1:0]  sq_wdata,
    input  logic [BUS_W-1:0]  mem_rdata,
    output logic              sq_lock
);

    seq_state_t        state;
    logic [BUS_W-1:0]  held_word;
    logic [ADDR_W-1:0] held_addr;
    logic [BIT_W-1:0]  held_bit;
    logic              held_val;
    logic              start_rmw;

    assign start_rmw = (state == SEQ_IDLE) && cpu_req && cpu_we && alias_hit;

    // Downstream drive, processor response and lock for the current state.
    always_comb begin
        sq_req    = 1'b0;
        sq_we     = 1'b0;
        sq_addr   = cpu_addr;
        sq_wdata  = cpu_wdata;
        cpu_rdata = '0;
        cpu_ready = 1'b0;
        sq_lock   = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                if (cpu_req) begin
                    sq_req = 1'b1;
                    if (alias_hit) begin
                        sq_addr = alias_word;
                        if (cpu_we) begin
                            sq_lock = 1'b1;
                        end else begin
                            cpu_ready = 1'b1;
                            cpu_rdata = {{(BUS_W-1){1'b0}}, mem_rdata[alias_bit]};
                        end
                    end else begin
                        sq_we     = cpu_we;
                        cpu_ready = 1'b1;
                        cpu_rdata = mem_rdata;
                    end
                end
            end
            SEQ_MERGE: begin
                sq_req    = 1'b1;
                sq_we     = 1'b1;
                sq_addr   = held_addr;
                sq_wdata  = put_bit(held_word, held_bit, held_val);
                sq_lock   = 1'b1;
                cpu_ready = 1'b1;
            end
            default: ;
        endcase
    end

    // State advance: enter the merge cycle after the locked read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else if (start_rmw) begin
            state <= SEQ_MERGE;
        end else begin
            state <= SEQ_IDLE;
        end
    end

    // Capture the word read in the locked cycle and what to change in it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_word <= '0;
            held_addr <= '0;
            held_bit  <= '0;
            held_val  <= 1'b0;
        end else if (start_rmw) begin
            held_word <= mem_rdata;
            held_addr <= alias_word;
            held_bit  <= alias_bit;
            held_val  <= cpu_wdata[0];
        end
    end

endmodule

// File: rtl/bitalias_arb.sv
// Downstream arbiter: hands the bus to the second requester only when the
// processor port is idle and no locked sequence runs; otherwise the
// sequencer drives the bus. Assumes same-cycle read data downstream.
module bitalias_arb
    import bitalias_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              cpu_req,
    input  logic              sq_req,
    input  logic              sq_we,
    input  logic [ADDR_W-1:0] sq_addr,
    input  logic [BUS_W-1:0]  sq_wdata,
    input  logic              sq_lock,
    input  logic              dma_req,
    input  logic              dma_we,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [BUS_W-1:0]  dma_wdata,
    output logic [BUS_W-1:0]  dma_rdata,
    output logic              dma_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BUS_W-1:0]  mem_wdata,
    input  logic [BUS_W-1:0]  mem_rdata
);

    logic dma_grant;

    assign dma_grant = dma_req && !cpu_req && !sq_lock;

    // Select the bus owner for this cycle.
    always_comb begin
        if (dma_grant) begin
            mem_req   = 1'b1;
            mem_we    = dma_we;
            mem_addr  = dma_addr;
            mem_wdata = dma_wdata;
        end else begin
            mem_req   = sq_req;
            mem_we    = sq_we;
            mem_addr  = sq_addr;
            mem_wdata = sq_wdata;
        end
    end

    assign dma_ready = dma_grant;
    assign dma_rdata = mem_rdata;

endmodule

// File: rtl/bitalias_bridge.sv
// Bit-alias bridge top: decodes processor addresses into alias windows,
// runs locked read-modify-writes for alias writes and shares the downstream
// bank with a word-only second requester.
module bitalias_bridge
    import bitalias_pkg::*;
#(
    parameter int                ADDR_W          = 32,
    parameter int                REGION_WORDS    = 262144,
    parameter logic [ADDR_W-1:0] SRAM_ALIAS_BASE = 32'h2200_0000,
    parameter logic [ADDR_W-1:0] SRAM_WORD_BASE  = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] PERI_ALIAS_BASE = 32'h4200_0000,
    parameter logic [ADDR_W-1:0] PERI_WORD_BASE  = 32'h4000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_ready,
    input  logic              dma_req,
    input  logic              dma_we,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [31:0]       dma_wdata,
    output logic [31:0]       dma_rdata,
    output logic              dma_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              mem_lock
);

    logic              alias_hit;
    logic [ADDR_W-1:0] alias_word;
    logic [BIT_W-1:0]  alias_bit;
    logic              sq_req;
    logic              sq_we;
    logic [ADDR_W-1:0] sq_addr;
    logic [BUS_W-1:0]  sq_wdata;
    logic              sq_lock;

    bitalias_decode #(
        .ADDR_W          (ADDR_W),
        .REGION_WORDS    (REGION_WORDS),
        .SRAM_ALIAS_BASE (SRAM_ALIAS_BASE),
        .SRAM_WORD_BASE  (SRAM_WORD_BASE),
        .PERI_ALIAS_BASE (PERI_ALIAS_BASE),
        .PERI_WORD_BASE  (PERI_WORD_BASE)
    ) u_decode (
        .addr      (cpu_addr),
        .hit       (alias_hit),
        .word_addr (alias_word),
        .bit_idx   (alias_bit)
    );

    bitalias_rmw_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .cpu_ready  (cpu_ready),
        .alias_hit  (alias_hit),
        .alias_word (alias_word),
        .alias_bit  (alias_bit),
        .sq_req     (sq_req),
        .sq_we      (sq_we),
        .sq_addr    (sq_addr),
        .sq_wdata   (sq_wdata),
        .mem_rdata  (mem_rdata),
        .sq_lock    (sq_lock)
    );

    bitalias_arb #(.ADDR_W(ADDR_W)) u_arb (
        .cpu_req   (cpu_req),
        .sq_req    (sq_req),
        .sq_we     (sq_we),
        .sq_addr   (sq_addr),
        .sq_wdata  (sq_wdata),
        .sq_lock   (sq_lock),
        .dma_req   (dma_req),
        .dma_we    (dma_we),
        .dma_addr  (dma_addr),
        .dma_wdata (dma_wdata),
        .dma_rdata (dma_rdata),
        .dma_ready (dma_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    assign mem_lock = sq_lock;

endmodule

// File: rtl/bitalias_bridge_chk.sv
// Property checker for the bit-alias bridge, attached by bind. Relates the
// lock, the downstream strobes and the two ready signals over time.
module bitalias_bridge_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_ready,
    input logic [31:0]       cpu_rdata,
    input logic              dma_req,
    input logic              dma_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic [31:0]       mem_rdata,
    input logic              mem_lock,
    input logic              alias_hit
);

    p_alias_read_zero_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && !cpu_we && alias_hit && !mem_lock) |-> (cpu_rdata[31:1] == '0));

    p_one_bit_changes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && mem_req && !mem_we) |=> ($countones(mem_wdata ^ $past(mem_rdata)) <= 1));

    p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && mem_req && !mem_we) |=> (mem_lock && mem_req && mem_we && cpu_ready));

    p_same_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && mem_req && !mem_we) |=> (mem_addr == $past(mem_addr)));

    p_cpu_stall_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ready) |=> cpu_ready);

    p_lock_read_holds_cpu_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && !mem_we) |-> !cpu_ready);

    p_lock_blocks_dma_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_lock |-> !dma_ready);

    p_cpu_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && dma_req) |-> !dma_ready);

endmodule

bind bitalias_bridge bitalias_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_ready (cpu_ready),
    .cpu_rdata (cpu_rdata),
    .dma_req   (dma_req),
    .dma_ready (dma_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_lock  (mem_lock),
    .alias_hit (alias_hit)
);

// File: tb/sim_bitalias_bridge.sv
`timescale 1ns/1ps
// Bench: sweeps every alias address of a four-word configuration in both
// windows, checks plain and boundary accesses and the lock contention cases.
module sim_bitalias_bridge;

    localparam int          NW     = 4;
    localparam logic [31:0] SA     = 32'h2200_0000;
    localparam logic [31:0] SW     = 32'h2000_0000;
    localparam logic [31:0] PA     = 32'h4200_0000;
    localparam logic [31:0] PW     = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        dma_req = 1'b0, dma_we = 1'b0;
    logic [31:0] dma_addr = '0, dma_wdata = '0;
    logic [31:0] dma_rdata;
    logic        dma_ready;
    logic        mem_req, mem_we, mem_lock;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [64];
    logic [31:0] exp_mem [64];
    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    bitalias_bridge #(
        .ADDR_W(32), .REGION_WORDS(NW),
        .SRAM_ALIAS_BASE(SA), .SRAM_WORD_BASE(SW),
        .PERI_ALIAS_BASE(PA), .PERI_WORD_BASE(PW)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
        .dma_rdata(dma_rdata), .dma_ready(dma_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_lock(mem_lock)
    );

    function automatic int midx(input logic [31:0] a);
        return int'({a[30], a[25], a[5:2]});
    endfunction

    function automatic logic [31:0] seed(input int i);
        return 32'(i) * 32'h9E37_79B1;
    endfunction

    // Downstream bank model: same-cycle read, write at the clock edge.
    assign mem_rdata = mem[midx(mem_addr)];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= seed(i);
        end else if (mem_req && mem_we) begin
            mem[midx(mem_addr)] <= mem_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_xfer(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                            output logic [31:0] rd, output int cyc, output int lk);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        cyc = 0; lk = 0; rd = '0;
        forever begin
            #1;
            cyc++;
            if (mem_lock) lk++;
            if (cpu_ready) begin rd = cpu_rdata; break; end
            if (cyc > 20) break;
            @(negedge clk);
        end
        @(posedge clk); #1;
        cpu_req = 1'b0;
    endtask

    task automatic dma_xfer(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                            output logic [31:0] rd, output int cyc);
        @(negedge clk);
        dma_req = 1'b1; dma_we = we; dma_addr = addr; dma_wdata = wd;
        cyc = 0; rd = '0;
        forever begin
            #1;
            cyc++;
            if (dma_ready) begin rd = dma_rdata; break; end
            if (cyc > 20) break;
            @(negedge clk);
        end
        @(posedge clk); #1;
        dma_req = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    function automatic logic [31:0] abase(input int r);
        return (r == 0) ? SA : PA;
    endfunction

    function automatic logic [31:0] wbase(input int r);
        return (r == 0) ? SW : PW;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        summary();
    end

    initial begin
        logic [31:0] rd, rd2, wa, aa, wd;
        int cyc, cyc2, lk;
        logic v;
        for (int i = 0; i < 64; i++) exp_mem[i] = seed(i);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R10: idle after reset
        check(mem_lock == 1'b0, "R10 lock", 32'(mem_lock), 32'd0);
        check(cpu_ready == 1'b0 && dma_ready == 1'b0, "R10 ready", {cpu_ready, dma_ready}, 32'd0);

        // R7: plain reads of every covered word
        for (int r = 0; r < 2; r++) begin
            for (int w = 0; w < NW; w++) begin
                wa = wbase(r) + 32'(w * 4);
                cpu_xfer(1'b0, wa, '0, rd, cyc, lk);
                check(rd == exp_mem[midx(wa)] && cyc == 1 && lk == 0, "R7 plain read", rd, exp_mem[midx(wa)]);
            end
        end

        // R1 R2: alias read sweep over both windows
        for (int r = 0; r < 2; r++) begin
            for (int w = 0; w < NW; w++) begin
                for (int b = 0; b < 32; b++) begin
                    wa = wbase(r) + 32'(w * 4);
                    aa = abase(r) + 32'(w * 128) + 32'(b * 4) + 32'(b % 4);
                    cpu_xfer(1'b0, aa, '0, rd, cyc, lk);
                    check(rd == 32'((exp_mem[midx(wa)] >> b) & 32'd1) && cyc == 1 && lk == 0,
                          "R1 R2 alias read", rd, (exp_mem[midx(wa)] >> b) & 32'd1);
                end
            end
        end

        // R3 R4 R5 R6: alias write sweep, then word readback
        for (int r = 0; r < 2; r++) begin
            for (int w = 0; w < NW; w++) begin
                wa = wbase(r) + 32'(w * 4);
                for (int b = 0; b < 32; b++) begin
                    v  = ((b + w + r) % 3) == 0;
                    aa = abase(r) + 32'(w * 128) + 32'(b * 4);
                    wd = ((32'(b + 1) * 32'h0123_4567) & 32'hFFFF_FFFE) | 32'(v);
                    cpu_xfer(1'b1, aa, wd, rd, cyc, lk);
                    exp_mem[midx(wa)][b] = v;
                    check(cyc == 2, "R5 two cycles", 32'(cyc), 32'd2);
                    check(lk == 2, "R6 lock both cycles", 32'(lk), 32'd2);
                end
                cpu_xfer(1'b0, wa, '0, rd, cyc, lk);
                check(rd == exp_mem[midx(wa)], "R3 R4 merged word", rd, exp_mem[midx(wa)]);
            end
        end

        // R3: alias readback of written bits
        for (int r = 0; r < 2; r++) begin
            for (int w = 0; w < NW; w++) begin
                for (int b = 0; b < 32; b++) begin
                    wa = wbase(r) + 32'(w * 4);
                    aa = abase(r) + 32'(w * 128) + 32'(b * 4);
                    cpu_xfer(1'b0, aa, '0, rd, cyc, lk);
                    check(rd == ((exp_mem[midx(wa)] >> b) & 32'd1), "R3 alias readback",
                          rd, (exp_mem[midx(wa)] >> b) & 32'd1);
                end
            end
        end

        // R7: word just past and just below the memory alias window
        aa = SA + 32'(NW * 128);
        cpu_xfer(1'b1, aa, 32'hCAFE_0001, rd, cyc, lk);
        exp_mem[midx(aa)] = 32'hCAFE_0001;
        check(cyc == 1 && lk == 0, "R7 past window write", 32'(cyc), 32'd1);
        cpu_xfer(1'b0, aa, '0, rd, cyc, lk);
        check(rd == 32'hCAFE_0001, "R7 past window read", rd, 32'hCAFE_0001);
        cpu_xfer(1'b0, SW, '0, rd, cyc, lk);
        check(rd == exp_mem[midx(SW)], "R7 target untouched", rd, exp_mem[midx(SW)]);
        aa = SA - 32'd4;
        cpu_xfer(1'b1, aa, 32'h0BAD_F00D, rd, cyc, lk);
        exp_mem[midx(aa)] = 32'h0BAD_F00D;
        cpu_xfer(1'b0, aa, '0, rd, cyc, lk);
        check(rd == 32'h0BAD_F00D && cyc == 1, "R7 below window", rd, 32'h0BAD_F00D);

        // R8: alias write and a second-requester write to the same word together
        wa = SW + 32'd4;
        fork
            cpu_xfer(1'b1, SA + 32'd128 + 32'd28, 32'd1, rd, cyc, lk);
            dma_xfer(1'b1, wa, 32'h1234_5678, rd2, cyc2);
        join
        check(cyc == 2, "R8 cpu cycles", 32'(cyc), 32'd2);
        check(cyc2 == 3, "R8 dma stalled", 32'(cyc2), 32'd3);
        exp_mem[midx(wa)] = 32'h1234_5678;
        cpu_xfer(1'b0, wa, '0, rd, cyc, lk);
        check(rd == 32'h1234_5678, "R8 final word", rd, 32'h1234_5678);

        // R8: second requester arrives on the write-back cycle
        wa = PW + 32'd8;
        fork
            cpu_xfer(1'b1, PA + 32'd256 + 32'd4, 32'd0, rd, cyc, lk);
            begin
                @(negedge clk);
                dma_xfer(1'b1, wa, 32'h5A5A_A5A5, rd2, cyc2);
            end
        join
        check(cyc2 == 2, "R8 late dma stalled", 32'(cyc2), 32'd2);
        exp_mem[midx(wa)] = 32'h5A5A_A5A5;
        cpu_xfer(1'b0, wa, '0, rd, cyc, lk);
        check(rd == 32'h5A5A_A5A5, "R8 late final word", rd, 32'h5A5A_A5A5);

        // R9: plain read and second-requester write in the same idle cycle
        wa = SW + 32'd12;
        fork
            cpu_xfer(1'b0, wa, '0, rd, cyc, lk);
            dma_xfer(1'b1, wa, 32'h7777_0000, rd2, cyc2);
        join
        check(rd == exp_mem[midx(wa)] && cyc == 1, "R9 cpu first", rd, exp_mem[midx(wa)]);
        check(cyc2 == 2, "R9 dma waits", 32'(cyc2), 32'd2);
        exp_mem[midx(wa)] = 32'h7777_0000;
        dma_xfer(1'b0, wa, '0, rd2, cyc2);
        check(rd2 == 32'h7777_0000, "R9 dma data", rd2, 32'h7777_0000);

        summary();
    end

endmodule